// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block sits between two 8-bit buses, A and B, and moves data in either direction. Each direction has a storage register. The A-to-B register samples the A-side input, and the B-to-A register samples the B-side input. Each output port drives one of two sources: live data from the opposite port, or the contents of that direction's register. Because capture does not depend on any of the output controls, a user can store a word, pipeline words, or replay a stored word in either direction while the buses carry other traffic.

Tri-state pins are split into three parts for each port: an input vector, an output-value vector and an output-enable vector. The surrounding pad logic resolves them, so the block itself stays fully synthesizable.

The two capture strobes are treated as edge clocks. Each strobe is edge-detected in the system clock domain, and a rising transition loads its register at that clock edge.

A parameter picks the output-enable style:
- **Single style:** a shared active-low enable plus a direction bit.
- **Dual style:** two independent enables. When the two enables are tied together, they act as a direction bit.

Top module: `dual_reg_xcvr`

## Requirements
- R1: When `cap_ab_i` is high at a clock edge and was low at the previous edge, the A-to-B register loads `a_i` at that edge. The new value is visible from the following cycle.
- R2: When `cap_ba_i` is high at a clock edge and was low at the previous edge, the B-to-A register loads `b_i` at that edge. The new value is visible from the following cycle.
- R3: Capture does not depend on the selects, enables or direction. A register keeps its value at every edge without a strobe rise. Registers load only from the external input vectors `a_i`/`b_i` and never from the block's own outputs.
- R4: When port B is enabled, `b_o` equals `a_i` if `sel_ab_i`=0, and the A-to-B register if `sel_ab_i`=1.
- R5: When port A is enabled, `a_o` equals `b_i` if `sel_ba_i`=0, and the B-to-A register if `sel_ba_i`=1.
- R6: In single style (`OE_STYLE`=OE_SINGLE), nothing is enabled while `oe_n_i`=1. With `oe_n_i`=0, `dir_i`=0 enables port A only and `dir_i`=1 enables port B only.
- R7: In dual style (`OE_STYLE`=OE_DUAL), `oe_ab_i`=1 enables port B and `oe_ba_n_i`=0 enables port A, each independently of the other. Tying both enables to one signal gives the same outputs as single style with `oe_n_i`=0 and `dir_i` equal to that signal.
- R8: A disabled port has its enable vector all zero and its value vector all zero. An enabled port has its enable vector all ones.
- R9: While `rst_ni`=0, both enable vectors are zero and both registers clear to zero. A strobe held high through reset does not count as a rising edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | WIDTH | Value seen on the A-side pins |
| b_i | input | WIDTH | Value seen on the B-side pins |
| cap_ab_i | input | 1 | Capture strobe for the A-to-B register (rising edge) |
| cap_ba_i | input | 1 | Capture strobe for the B-to-A register (rising edge) |
| sel_ab_i | input | 1 | B output source: 0 live A, 1 stored |
| sel_ba_i | input | 1 | A output source: 0 live B, 1 stored |
| oe_n_i | input | 1 | Single style: shared active-low enable |
| dir_i | input | 1 | Single style: 0 drive A, 1 drive B |
| oe_ab_i | input | 1 | Dual style: active-high enable of port B |
| oe_ba_n_i | input | 1 | Dual style: active-low enable of port A |
| a_o | output | WIDTH | Value driven onto the A-side pins |
| a_oe_o | output | WIDTH | Per-pin enable for port A |
| b_o | output | WIDTH | Value driven onto the B-side pins |
| b_oe_o | output | WIDTH | Per-pin enable for port B |

## Verification
The assertions take the following for granted:
- Every input, including both capture strobes, is synchronous to `clk_i` and stable around its rising edge. This means a strobe rise is observed at exactly one edge.
- The external pad logic, not this block, prevents a port's input from echoing its own output.

The stimulus changes every input only on the falling clock edge. It walks all 256 combinations of strobes, selects and enable controls several times, with fresh data each time. It also toggles the strobes across reset release, so that a held level is shown to produce no capture.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    OE_SINGLE = 1'b0,
    OE_DUAL   = 1'b1
  } oe_style_e;
endpackage

// File: rtl/xcvr_cap_edge.sv
module xcvr_cap_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic fire_o
);
  logic strobe_q;

  // reset to 1: a level held through reset is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b1;
    else         strobe_q <= strobe_i;
  end

  assign fire_o = strobe_i & ~strobe_q;

  assert_single_fire_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);
endmodule

// File: rtl/xcvr_dir_store.sv
module xcvr_dir_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

  assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q_o == $past(d_i));
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o));
endmodule

// File: rtl/xcvr_oe_decode.sv
module xcvr_oe_decode
  import xcvr_pkg::*;
#(
  parameter oe_style_e OE_STYLE = OE_SINGLE
) (
  input  logic oe_n_i,
  input  logic dir_i,
  input  logic oe_ab_i,
  input  logic oe_ba_n_i,
  output logic a_en_o,
  output logic b_en_o
);
  if (OE_STYLE == OE_SINGLE) begin : g_single
    logic unused_dual;
    assign unused_dual = oe_ab_i ^ oe_ba_n_i;
    assign a_en_o = ~oe_n_i & ~dir_i;
    assign b_en_o = ~oe_n_i &  dir_i;
  end else begin : g_dual
    logic unused_single;
    assign unused_single = oe_n_i ^ dir_i;
    assign a_en_o = ~oe_ba_n_i;
    assign b_en_o =  oe_ab_i;
  end
endmodule

// File: rtl/xcvr_port_drive.sv
module xcvr_port_drive #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] live_i,
  input  logic [WIDTH-1:0] stored_i,
  input  logic             sel_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] val_o,
  output logic [WIDTH-1:0] oe_o
);
  always_comb begin
    val_o = '0;
    if (en_i) val_o = sel_i ? stored_i : live_i;
  end
  assign oe_o = {WIDTH{en_i}};
endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr
  import xcvr_pkg::*;
#(
  parameter int        WIDTH    = 8,
  parameter oe_style_e OE_STYLE = OE_SINGLE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cap_ab_i,
  input  logic             cap_ba_i,
  input  logic             sel_ab_i,
  input  logic             sel_ba_i,
  input  logic             oe_n_i,
  input  logic             dir_i,
  input  logic             oe_ab_i,
  input  logic             oe_ba_n_i,
  output logic [WIDTH-1:0] a_o,
  output logic [WIDTH-1:0] a_oe_o,
  output logic [WIDTH-1:0] b_o,
  output logic [WIDTH-1:0] b_oe_o
);
  logic             fire_ab, fire_ba;
  logic [WIDTH-1:0] store_ab, store_ba;
  logic             a_en_raw, b_en_raw, a_en, b_en;

  xcvr_cap_edge u_edge_ab (.clk_i, .rst_ni, .strobe_i(cap_ab_i), .fire_o(fire_ab));
  xcvr_cap_edge u_edge_ba (.clk_i, .rst_ni, .strobe_i(cap_ba_i), .fire_o(fire_ba));

  // registers load from the external input side only
  xcvr_dir_store #(.WIDTH(WIDTH)) u_store_ab (
    .clk_i, .rst_ni, .load_i(fire_ab), .d_i(a_i), .q_o(store_ab));
  xcvr_dir_store #(.WIDTH(WIDTH)) u_store_ba (
    .clk_i, .rst_ni, .load_i(fire_ba), .d_i(b_i), .q_o(store_ba));

  xcvr_oe_decode #(.OE_STYLE(OE_STYLE)) u_oe (
    .oe_n_i, .dir_i, .oe_ab_i, .oe_ba_n_i, .a_en_o(a_en_raw), .b_en_o(b_en_raw));

  assign a_en = a_en_raw & rst_ni;
  assign b_en = b_en_raw & rst_ni;

  xcvr_port_drive #(.WIDTH(WIDTH)) u_drive_b (
    .live_i(a_i), .stored_i(store_ab), .sel_i(sel_ab_i), .en_i(b_en),
    .val_o(b_o), .oe_o(b_oe_o));
  xcvr_port_drive #(.WIDTH(WIDTH)) u_drive_a (
    .live_i(b_i), .stored_i(store_ba), .sel_i(sel_ba_i), .en_i(a_en),
    .val_o(a_o), .oe_o(a_oe_o));

  always_comb begin
    if (!rst_ni) assert_reset_quiet_R9: assert (a_oe_o == '0 && b_oe_o == '0);
  end

  assert_disabled_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !b_oe_o[0] |-> b_o == '0);

  assert_stored_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_oe_o[0] && sel_ab_i && !fire_ab) |=> (sel_ab_i && b_oe_o[0]) -> b_o == $past(b_o));

  if (OE_STYLE == OE_SINGLE) begin : g_chk_single
    assert_one_side_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(a_oe_o[0] && b_oe_o[0]));
  end
endmodule

// File: tb/dual_reg_xcvr_tb_top.sv
module dual_reg_xcvr_tb_top;
  import xcvr_pkg::*;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic cap_ab = 0, cap_ba = 0, sel_ab = 0, sel_ba = 0;
  logic oe_n = 1, dir = 0, oe_ab = 0, oe_ba_n = 1;
  logic [W-1:0] s_a, s_aoe, s_b, s_boe, d_a, d_aoe, d_b, d_boe;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  string phase = "init";

  // behavioural model state
  logic [W-1:0] m_ab = '0, m_ba = '0;
  bit prev_ab = 1, prev_ba = 1;

  always #2 clk = ~clk;

  dual_reg_xcvr #(.WIDTH(W), .OE_STYLE(OE_SINGLE)) dut_i (
    .clk_i(clk), .rst_ni, .a_i, .b_i, .cap_ab_i(cap_ab), .cap_ba_i(cap_ba),
    .sel_ab_i(sel_ab), .sel_ba_i(sel_ba), .oe_n_i(oe_n), .dir_i(dir),
    .oe_ab_i(oe_ab), .oe_ba_n_i(oe_ba_n),
    .a_o(s_a), .a_oe_o(s_aoe), .b_o(s_b), .b_oe_o(s_boe));

  dual_reg_xcvr #(.WIDTH(W), .OE_STYLE(OE_DUAL)) dut_dual_i (
    .clk_i(clk), .rst_ni, .a_i, .b_i, .cap_ab_i(cap_ab), .cap_ba_i(cap_ba),
    .sel_ab_i(sel_ab), .sel_ba_i(sel_ba), .oe_n_i(oe_n), .dir_i(dir),
    .oe_ab_i(oe_ab), .oe_ba_n_i(oe_ba_n),
    .a_o(d_a), .a_oe_o(d_aoe), .b_o(d_b), .b_oe_o(d_boe));

  task automatic cmp(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s [%s] %s: actual %h expected %h", req, phase, what, act, exp);
    end
  endtask

  // compare both instances against the model, before the coming edge
  task automatic check_all();
    bit sa, sb, da, db;
    logic [W-1:0] src_b, src_a;
    string rb, ra;
    src_b = sel_ab ? m_ab : a_i;
    src_a = sel_ba ? m_ba : b_i;
    rb = sel_ab ? "R1" : "R4";
    ra = sel_ba ? "R2" : "R5";
    sa = rst_ni && !oe_n && !dir;      // R6
    sb = rst_ni && !oe_n && dir;
    da = rst_ni && !oe_ba_n;           // R7
    db = rst_ni && oe_ab;
    cmp(rst_ni ? "R6" : "R9", "single a_oe", s_aoe, {W{sa}});
    cmp(rst_ni ? "R6" : "R9", "single b_oe", s_boe, {W{sb}});
    cmp(rst_ni ? "R7" : "R9", "dual a_oe", d_aoe, {W{da}});
    cmp(rst_ni ? "R7" : "R9", "dual b_oe", d_boe, {W{db}});
    cmp(sa ? ra : "R8", "single a_o", s_a, sa ? src_a : '0);
    cmp(sb ? rb : "R8", "single b_o", s_b, sb ? src_b : '0);
    cmp(da ? ra : "R8", "dual a_o", d_a, da ? src_a : '0);
    cmp(db ? rb : "R8", "dual b_o", d_b, db ? src_b : '0);
  endtask

  // model update at the edge: R1, R2, R3 (load from inputs regardless of controls), R9
  always @(posedge clk) begin
    if (!rst_ni) begin
      m_ab = '0; m_ba = '0; prev_ab = 1; prev_ba = 1;
    end else begin
      if (cap_ab && !prev_ab) m_ab = a_i;
      if (cap_ba && !prev_ba) m_ba = b_i;
      prev_ab = cap_ab;
      prev_ba = cap_ba;
    end
  end

  task automatic step();
    #1 check_all();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R9: reset state, strobes held high through reset release
    phase = "reset R9";
    @(negedge clk);
    cap_ab = 1; cap_ba = 1; oe_n = 0; oe_ab = 1; oe_ba_n = 0;
    a_i = 8'h5A; b_i = 8'hA5; sel_ab = 1; sel_ba = 1;
    repeat (3) step();
    rst_ni = 1;
    repeat (3) step();   // held strobe must not capture: stored stays zero
    cap_ab = 0; cap_ba = 0;
    step();

    // R3: sweep every control combination with fresh data
    phase = "sweep R3";
    for (int pass = 0; pass < 6; pass++) begin
      for (int c = 0; c < 256; c++) begin
        a_i = W'($urandom); b_i = W'($urandom);
        {cap_ab, cap_ba, sel_ab, sel_ba, oe_n, dir, oe_ab, oe_ba_n} = c[7:0];
        step();
      end
    end

    // R1 and R2: store, then replay after the live data moves on
    phase = "replay R1 R2";
    cap_ab = 0; cap_ba = 0; step();
    a_i = 8'h3C; b_i = 8'hC3; cap_ab = 1; cap_ba = 1; oe_n = 1; step();
    cap_ab = 0; cap_ba = 0; a_i = 8'h00; b_i = 8'hFF;
    sel_ab = 1; sel_ba = 1; oe_n = 0; dir = 1; oe_ab = 1; oe_ba_n = 0;
    repeat (2) step();
    dir = 0; step();

    // R7: tied dual enables match single style with oe_n low
    phase = "tied R7";
    oe_n = 0;
    for (int k = 0; k < 16; k++) begin
      dir = k[0]; oe_ab = k[0]; oe_ba_n = k[0];
      sel_ab = k[1]; sel_ba = k[2]; a_i = W'($urandom); b_i = W'($urandom);
      #1;
      cmp("R7", "tied a_o", d_a, s_a);
      cmp("R7", "tied b_o", d_b, s_b);
      cmp("R7", "tied a_oe", d_aoe, s_aoe);
      cmp("R7", "tied b_oe", d_boe, s_boe);
      check_all();
      @(negedge clk);
    end

    // R9: reset in mid-run clears stored data and enables
    phase = "rereset R9";
    rst_ni = 0; step();
    rst_ni = 1; cap_ab = 0; cap_ba = 0; step();
    sel_ab = 1; sel_ba = 1; oe_ab = 1; oe_ba_n = 0; step();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule